// File: doc/BRIEF.md
# Cache Control Register Block with Unlock Key

This block holds the control settings for an instruction cache and a data cache that sit side by side. A simple synchronous register bus has two locations: a setup register and a write-only unlock register. The setup register can be changed only right after the unlock value 0xF123F456 has been written to the unlock register. Any setup write, whether or not it is accepted, uses up the unlock, so every protected change needs a new key.

For each cache the block drives an enable, a lock (no allocation on new misses), and buffer hit-check bypass controls. It also raises an init request that asks that cache to zero-fill its contents. Setting a cache's init bit turns that cache's enable and lock off. The request stays up until the cache answers with a one-cycle init-started pulse, and the bit clears on the next clock.

The design is built around two small state machines. The key guard has the states KEY_SHUT and KEY_ARMED. It moves from KEY_SHUT to KEY_ARMED on an unlock write carrying the correct value. It falls back to KEY_SHUT on an unlock write with any other value and on every setup write. Each cache side has an init sequencer with the states INIT_IDLE and INIT_WAIT. It moves from INIT_IDLE to INIT_WAIT on an accepted setup write whose init bit is 1, unless init-started arrives in the same cycle. It returns from INIT_WAIT to INIT_IDLE on init-started.

Top module: `cache_ctl_regs`

## Requirements
- R1: After reset the setup register reads 0x00000002. Only the instruction-cache enable is 1, and both init requests are 0.
- R2: A setup write takes effect only while the key guard is armed. Otherwise all setup fields keep their values.
- R3: Any setup write disarms the key guard, and an unlock write with a wrong value also disarms it. A later setup write without a new correct key is ignored.
- R4: Reading the unlock register address always returns 0.
- R5: Setup bits 31:20 and 15:5 read as 0 whatever was written to them.
- R6: An accepted setup write with an init bit of 1 clears that cache's enable and lock, whatever values were written to them. The other cache is unaffected.
- R7: The init request stays 1 until init-started is seen, and it is 0 from the clock after the pulse. An init-started pulse while no request is pending has no effect.
- R8: If init-started coincides with an accepted write that sets the same init bit, the init bit stays 0. The other written fields still take effect.
- R9: Writing 0 to an init bit that is pending does not cancel the request.
- R10: The control outputs follow the setup fields at these bit positions. Instruction side: init 0, enable 1, lock 2, write-buffer bypass 3, read-buffer bypass 4. Data side: init 16, enable 17, lock 18, write-buffer bypass 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on bus_addr) |
| ic_en | output | 1 | Instruction cache enable |
| ic_lock | output | 1 | Instruction cache no-allocate lock |
| ic_wbuf_skip | output | 1 | Instruction write-buffer hit check off |
| ic_rbuf_skip | output | 1 | Instruction read-buffer hit check off |
| ic_init_req | output | 1 | Instruction cache zero-fill request |
| ic_init_started | input | 1 | Instruction cache zero-fill started pulse |
| dc_en | output | 1 | Data cache enable |
| dc_lock | output | 1 | Data cache no-allocate lock |
| dc_wbuf_skip | output | 1 | Data write-buffer hit check off |
| dc_init_req | output | 1 | Data cache zero-fill request |
| dc_init_started | input | 1 | Data cache zero-fill started pulse |

## Verification
A cache's init-started pulse can fall in the same cycle as an accepted setup write that sets that cache's init bit. The bench provokes this by holding dc_init_started high during the write cycle of a keyed setup write, with the data-side init bit and the instruction-side enable and lock set in the written data. The outcome counts as correct when the data init request stays low while the instruction-side fields still change. A pending request that is rewritten with init 0 is also checked, to confirm that the request survives until its pulse arrives.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;

    localparam int unsigned NSIDE   = 2;
    localparam int unsigned FIELD_W = 5;

    localparam int unsigned OFS_INIT = 0;
    localparam int unsigned OFS_EN   = 1;
    localparam int unsigned OFS_LOCK = 2;
    localparam int unsigned OFS_WBUF = 3;
    localparam int unsigned OFS_RBUF = 4;

    localparam int unsigned SIDE_IC = 0;
    localparam int unsigned SIDE_DC = 1;

    localparam int unsigned SIDE_BASE   [NSIDE] = '{0, 16};
    localparam bit          SIDE_RBUF   [NSIDE] = '{1'b1, 1'b0};
    localparam bit          SIDE_EN_RST [NSIDE] = '{1'b1, 1'b0};

    localparam logic [31:0] USED_MASK = 32'h000F_001F;

    typedef enum logic {
        KEY_SHUT  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_t;

    typedef enum logic {
        INIT_IDLE = 1'b0,
        INIT_WAIT = 1'b1
    } init_state_t;

endpackage

// File: rtl/ccr_key_guard.sv
module ccr_key_guard
    import cache_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_match,
    input  logic setup_wr,
    output logic armed_o
);

    key_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_SHUT: begin
                if (key_wr && key_match) begin
                    state_d = KEY_ARMED;
                end
            end
            KEY_ARMED: begin
                if (setup_wr || (key_wr && !key_match)) begin
                    state_d = KEY_SHUT;
                end
            end
            default: state_d = KEY_SHUT;
        endcase
    end

    always_comb begin
        armed_o = (state_q == KEY_ARMED);
    end

endmodule

// File: rtl/ccr_side.sv
module ccr_side
    import cache_ctl_pkg::*;
#(
    parameter bit HAS_RBUF = 1'b1,
    parameter bit EN_RST   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [FIELD_W-1:0] wfield,
    input  logic               init_started,
    output logic [FIELD_W-1:0] fields_o
);

    localparam logic RBUF_KEEP = HAS_RBUF;

    init_state_t state_q, state_d;
    logic        init_wr;
    logic        en_q, lock_q, wbuf_q, rbuf_q;

    always_comb begin
        init_wr = wr_ok && wfield[OFS_INIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INIT_IDLE: begin
                if (init_wr && !init_started) begin
                    state_d = INIT_WAIT;
                end
            end
            INIT_WAIT: begin
                if (init_started) begin
                    state_d = INIT_IDLE;
                end
            end
            default: state_d = INIT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= EN_RST;
            lock_q <= 1'b0;
            wbuf_q <= 1'b0;
            rbuf_q <= 1'b0;
        end else if (wr_ok) begin
            en_q   <= wfield[OFS_EN]   && !wfield[OFS_INIT];
            lock_q <= wfield[OFS_LOCK] && !wfield[OFS_INIT];
            wbuf_q <= wfield[OFS_WBUF];
            rbuf_q <= wfield[OFS_RBUF] && RBUF_KEEP;
        end
    end

    always_comb begin
        fields_o           = '0;
        fields_o[OFS_INIT] = (state_q == INIT_WAIT);
        fields_o[OFS_EN]   = en_q;
        fields_o[OFS_LOCK] = lock_q;
        fields_o[OFS_WBUF] = wbuf_q;
        fields_o[OFS_RBUF] = rbuf_q;
    end

endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
    import cache_ctl_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] SETUP_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h08,
    parameter logic [31:0]       UNLOCK_KEY = 32'hF123_F456
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ic_en,
    output logic              ic_lock,
    output logic              ic_wbuf_skip,
    output logic              ic_rbuf_skip,
    output logic              ic_init_req,
    input  logic              ic_init_started,
    output logic              dc_en,
    output logic              dc_lock,
    output logic              dc_wbuf_skip,
    output logic              dc_init_req,
    input  logic              dc_init_started
);

    logic               setup_wr;
    logic               key_wr;
    logic               key_match;
    logic               key_open;
    logic               wr_ok;
    logic [NSIDE-1:0]   side_start;
    logic [FIELD_W-1:0] side_bits [NSIDE];
    logic [31:0]        rd_setup;

    always_comb begin
        setup_wr  = bus_we && (bus_addr == SETUP_ADDR);
        key_wr    = bus_we && (bus_addr == KEY_ADDR);
        key_match = (bus_wdata == UNLOCK_KEY);
        wr_ok     = setup_wr && key_open;
    end

    ccr_key_guard u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_match (key_match),
        .setup_wr  (setup_wr),
        .armed_o   (key_open)
    );

    always_comb begin
        side_start[SIDE_IC] = ic_init_started;
        side_start[SIDE_DC] = dc_init_started;
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        ccr_side #(
            .HAS_RBUF (SIDE_RBUF[g]),
            .EN_RST   (SIDE_EN_RST[g])
        ) u_side (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_ok        (wr_ok),
            .wfield       (bus_wdata[SIDE_BASE[g] +: FIELD_W]),
            .init_started (side_start[g]),
            .fields_o     (side_bits[g])
        );
    end

    always_comb begin
        rd_setup = '0;
        for (int i = 0; i < NSIDE; i++) begin
            rd_setup[SIDE_BASE[i] +: FIELD_W] = side_bits[i];
        end
    end

    always_comb begin
        bus_rdata = (bus_addr == SETUP_ADDR) ? rd_setup : '0;
    end

    always_comb begin
        ic_init_req  = side_bits[SIDE_IC][OFS_INIT];
        ic_en        = side_bits[SIDE_IC][OFS_EN];
        ic_lock      = side_bits[SIDE_IC][OFS_LOCK];
        ic_wbuf_skip = side_bits[SIDE_IC][OFS_WBUF];
        ic_rbuf_skip = side_bits[SIDE_IC][OFS_RBUF];
        dc_init_req  = side_bits[SIDE_DC][OFS_INIT];
        dc_en        = side_bits[SIDE_DC][OFS_EN];
        dc_lock      = side_bits[SIDE_DC][OFS_LOCK];
        dc_wbuf_skip = side_bits[SIDE_DC][OFS_WBUF];
    end

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import cache_ctl_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              setup_wr,
    input logic              key_open,
    input logic              ic_en,
    input logic              ic_lock,
    input logic              ic_wbuf_skip,
    input logic              ic_rbuf_skip,
    input logic              ic_init_req,
    input logic              ic_init_started,
    input logic              dc_en,
    input logic              dc_lock,
    input logic              dc_wbuf_skip,
    input logic              dc_init_req,
    input logic              dc_init_started
);

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_wr && !key_open) |=> $stable({ic_en, ic_lock, ic_wbuf_skip, ic_rbuf_skip, dc_en, dc_lock, dc_wbuf_skip})); // R2
    AST_KEY_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        setup_wr |=> !key_open); // R3
    AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == KEY_ADDR) |-> (bus_rdata == 32'h0)); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~USED_MASK) == 32'h0)); // R5
    AST_IC_INIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ic_init_req) |-> (!ic_en && !ic_lock)); // R6
    AST_DC_INIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dc_init_req) |-> (!dc_en && !dc_lock)); // R6
    AST_IC_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_init_req && ic_init_started) |=> !ic_init_req); // R7
    AST_DC_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_init_req && dc_init_started) |=> !dc_init_req); // R7
    AST_IC_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_init_started && !ic_init_req) |=> !ic_init_req); // R8
    AST_DC_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_init_started && !dc_init_req) |=> !dc_init_req); // R8

endmodule

bind cache_ctl_regs ccr_checker #(
    .ADDR_W   (ADDR_W),
    .KEY_ADDR (KEY_ADDR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_rdata       (bus_rdata),
    .setup_wr        (setup_wr),
    .key_open        (key_open),
    .ic_en           (ic_en),
    .ic_lock         (ic_lock),
    .ic_wbuf_skip    (ic_wbuf_skip),
    .ic_rbuf_skip    (ic_rbuf_skip),
    .ic_init_req     (ic_init_req),
    .ic_init_started (ic_init_started),
    .dc_en           (dc_en),
    .dc_lock         (dc_lock),
    .dc_wbuf_skip    (dc_wbuf_skip),
    .dc_init_req     (dc_init_req),
    .dc_init_started (dc_init_started)
);

// File: tb/cache_ctl_regs_test.sv
`timescale 1ns/1ps
module cache_ctl_regs_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [7:0]  A_SETUP    = 8'h04;
    localparam logic [7:0]  A_KEY      = 8'h08;
    localparam logic [31:0] GOOD_KEY   = 32'hF123_F456;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic ic_en, ic_lock, ic_wbuf_skip, ic_rbuf_skip, ic_init_req;
    logic dc_en, dc_lock, dc_wbuf_skip, dc_init_req;
    logic ic_init_started = 1'b0;
    logic dc_init_started = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ic_en(ic_en), .ic_lock(ic_lock), .ic_wbuf_skip(ic_wbuf_skip),
        .ic_rbuf_skip(ic_rbuf_skip), .ic_init_req(ic_init_req),
        .ic_init_started(ic_init_started),
        .dc_en(dc_en), .dc_lock(dc_lock), .dc_wbuf_skip(dc_wbuf_skip),
        .dc_init_req(dc_init_req), .dc_init_started(dc_init_started)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_start(input bit dside);
        @(negedge clk);
        if (dside) dc_init_started = 1'b1; else ic_init_started = 1'b1;
        @(negedge clk);
        dc_init_started = 1'b0; ic_init_started = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_SETUP, v);
        chk("R1 setup reset value", v, 32'h0000_0002);
        chk("R1 ic_en reset", 32'(ic_en), 32'd1);
        chk("R1 init requests reset", 32'({ic_init_req, dc_init_req, dc_en}), 32'd0);
    endtask

    task automatic t_locked_write();
        logic [31:0] v;
        wr(A_SETUP, 32'h000F_001E);
        rd(A_SETUP, v);
        chk("R2 write without key ignored", v, 32'h0000_0002);
    endtask

    task automatic t_unlocked_write();
        logic [31:0] v;
        wr(A_KEY, GOOD_KEY);
        wr(A_SETUP, 32'h000E_001E);
        rd(A_SETUP, v);
        chk("R2 keyed write accepted", v, 32'h000E_001E);
        chk("R10 instruction outputs", 32'({ic_rbuf_skip, ic_wbuf_skip, ic_lock, ic_en}), 32'hF);
        chk("R10 data outputs", 32'({dc_wbuf_skip, dc_lock, dc_en}), 32'h7);
    endtask

    task automatic t_key_single_use();
        logic [31:0] v;
        wr(A_SETUP, 32'h0);
        rd(A_SETUP, v);
        chk("R3 key used up by prior write", v, 32'h000E_001E);
        wr(A_KEY, 32'h1234_5678);
        wr(A_SETUP, 32'h0);
        rd(A_SETUP, v);
        chk("R3 wrong key rejected", v, 32'h000E_001E);
        wr(A_KEY, GOOD_KEY);
        wr(A_KEY, 32'h0);
        wr(A_SETUP, 32'h0);
        rd(A_SETUP, v);
        chk("R3 overwritten key rejected", v, 32'h000E_001E);
    endtask

    task automatic t_key_read_reserved();
        logic [31:0] v;
        wr(A_KEY, GOOD_KEY);
        rd(A_KEY, v);
        chk("R4 key reads zero", v, 32'h0);
        wr(A_SETUP, 32'hFFFE_FFEE);
        rd(A_SETUP, v);
        chk("R5 reserved bits read zero", v, 32'h000E_000E);
    endtask

    task automatic t_ic_init();
        logic [31:0] v;
        wr(A_KEY, GOOD_KEY);
        wr(A_SETUP, 32'h000E_0007);
        rd(A_SETUP, v);
        chk("R6 ic init forces en/lock off", v, 32'h000E_0001);
        chk("R6 ic outputs off, dc kept", 32'({ic_init_req, ic_en, ic_lock, dc_en}), 32'b1001);
        repeat (3) @(negedge clk);
        chk("R7 ic request held", 32'(ic_init_req), 32'd1);
        wr(A_KEY, GOOD_KEY);
        wr(A_SETUP, 32'h000E_0000);
        chk("R9 pending ic request not cancelled", 32'(ic_init_req), 32'd1);
        pulse_start(1'b0);
        rd(A_SETUP, v);
        chk("R7 ic request cleared after pulse", v, 32'h000E_0000);
        pulse_start(1'b0);
        chk("R7 stray pulse no effect", 32'(ic_init_req), 32'd0);
    endtask

    task automatic t_dc_init();
        logic [31:0] v;
        wr(A_KEY, GOOD_KEY);
        wr(A_SETUP, 32'h0007_0002);
        rd(A_SETUP, v);
        chk("R6 dc init forces en/lock off", v, 32'h0001_0002);
        chk("R6 dc outputs", 32'({dc_init_req, dc_en, dc_lock, ic_en}), 32'b1001);
        pulse_start(1'b1);
        chk("R7 dc request cleared", 32'(dc_init_req), 32'd0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(A_KEY, GOOD_KEY);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_SETUP; bus_wdata = 32'h0001_0006;
        dc_init_started = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'h0; dc_init_started = 1'b0;
        chk("R8 start wins over init write", 32'(dc_init_req), 32'd0);
        rd(A_SETUP, v);
        chk("R8 other fields still written", v, 32'h0000_0006);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_write();
        t_unlocked_write();
        t_key_single_use();
        t_key_read_reserved();
        t_ic_init();
        t_dc_init();
        t_collision();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule